// File: doc/BRIEF.md
# UART Register Block with Read-Clear Status

This block is the software-facing register layer of a simple UART. A 32-bit word-addressed bus reads and writes eight registers. A byte-level character interface connects the block to the serialiser, and the block models only register semantics and interrupt generation. A transmit write produces a one-cycle byte strobe toward the serialiser. A received-byte strobe from the deserialiser loads the receive register, along with the line-error flags that come with that byte.

The status register holds sticky event flags. Reading status returns the current value and clears every error and event flag at once. Reading received data clears only the ready flag. A control register masks the status bits, and the OR of the unmasked bits drives the interrupt. The remaining register slots are plain storage.

Top module: `uart_regfile`

## Requirements
- R1: The word index is `addr[4:2]`. Higher address bits and `addr[1:0]` are ignored, so byte address 0x2C reaches the same register as 0x0C. Index map: 0 received data, 1 transmit data, 2 status, 3 control, 4 to 7 general storage.
- R2: A read of index 0 returns the last received byte, zero-extended, and clears receive-ready (status bit 7). The byte itself stays and can be read again. Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read.
- R3: A read of index 2 returns the status value from before the read. It then clears bits 0 parity, 1 framing, 2 break, 3 receive overrun, 4 transmit overrun, 6 CTS change and 8 error summary. Bit 7 receive-ready is not changed by this read. Bit 5 is a live transmit-ready bit equal to the inverse of `tx_busy`.
- R4: A write to index 1 stores all 32 bits, which read back unchanged. In the next cycle it drives `tx_strobe` high for exactly one cycle, with `tx_byte` equal to `wdata[7:0]`.
- R5: Writes to index 0 and index 2 change no register.
- R6: `rx_strobe` latches `rx_byte` into the received-data register and sets receive-ready. Its `rx_err` bits [0] parity, [1] framing and [2] break set status bits 0, 1 and 2. Any of these also sets the summary bit 8.
- R7: Indices 3 to 7 store written words unchanged and return them on read.
- R8: A byte that arrives while receive-ready is set, in a cycle with no read of index 0, sets receive overrun (bit 3) and the summary bit. The new byte replaces the old one.
- R9: A write to index 1 while `tx_busy` is high sets transmit overrun (bit 4) and the summary bit. The byte is still strobed out.
- R10: `irq` is the OR of status bits [8:0] ANDed with control bits [8:0]. It reflects register state after every access and event. A pulse on `cts_edge` sets bit 6.
- R11: A flag set and a read clear in the same cycle resolve to set. A receive-data read that coincides with `rx_strobe` returns the old byte, leaves receive-ready set and raises no overrun.
- R12: Reset (`rst_n` low, asynchronous) clears every register and `rdata`, and holds `tx_strobe` and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus byte address |
| wr_en | input | 1 | Write request |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| tx_strobe | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Byte to transmit |
| tx_busy | input | 1 | Serialiser busy |
| rx_strobe | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 3 | Line errors with the byte: [0] parity, [1] framing, [2] break |
| cts_edge | input | 1 | CTS changed pulse |
| irq | output | 1 | Interrupt request |

## Verification
A bus read that clears a flag can fall in the same cycle as the line event that sets it. The sharpest cases are a received-data read that coincides with a new byte, and a status read that coincides with a byte carrying a framing error. The bench drives both strobes in the same cycle. It then judges the returned value, which must be the pre-event value, and the status and `irq` that follow, where the new event's flags must survive and no overrun may appear.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          tx_strobe,
  output logic [BW-1:0] tx_byte,
  input  logic          tx_busy,
  input  logic          rx_strobe,
  input  logic [BW-1:0] rx_byte,
  input  logic [2:0]    rx_err,
  input  logic          cts_edge,
  output logic          irq
);
  localparam int NREG = 8;
  localparam int IW   = $clog2(NREG);
  localparam int NGEN = NREG - 3;
  localparam int SW   = 9;
  localparam logic [IW-1:0] I_RX = 0, I_TX = 1, I_ST = 2;
  localparam logic [SW-1:0] CLR_MASK = 9'b1_0101_1111;
  localparam int B_TRDY = 5, B_RRDY = 7;

  logic [IW-1:0] idx;
  logic          unused_addr;
  logic [BW-1:0] rx_q;
  logic [DW-1:0] tx_q;
  logic [DW-1:0] gen_q [NGEN];
  logic [SW-1:0] st_q, st_n, st_set, status;
  logic [DW-1:0] rd_mux;
  logic          rd_rx, rd_st, wr_tx, roe_set, toe_set;

  assign idx         = addr[IW+1:2];
  assign unused_addr = ^{addr[AW-1:IW+2], addr[1:0]};
  assign rd_rx = rd_en && idx == I_RX;
  assign rd_st = rd_en && idx == I_ST;
  assign wr_tx = wr_en && idx == I_TX;

  assign roe_set = rx_strobe && st_q[B_RRDY] && !rd_rx;
  assign toe_set = wr_tx && tx_busy;
  assign st_set[4:0]    = {toe_set, roe_set, {3{rx_strobe}} & rx_err};
  assign st_set[B_TRDY] = 1'b0;
  assign st_set[6]      = cts_edge;
  assign st_set[B_RRDY] = rx_strobe;
  assign st_set[8]      = |st_set[4:0];

  always_comb begin
    st_n = rd_st ? (st_q & ~CLR_MASK) : st_q;
    if (rd_rx) st_n[B_RRDY] = 1'b0;
    st_n = st_n | st_set;
  end

  assign status = st_q | (SW'(!tx_busy) << B_TRDY);
  assign irq    = |(status & gen_q[0][SW-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q      <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
      rdata     <= '0;
    end else begin
      st_q      <= st_n;
      tx_strobe <= wr_tx;
      if (rx_strobe) rx_q <= rx_byte;
      if (wr_tx) begin
        tx_q    <= wdata;
        tx_byte <= wdata[BW-1:0];
      end
      if (rd_en) rdata <= rd_mux;
    end

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) gen_q[g] <= '0;
      else if (wr_en && idx == IW'(g + 3)) gen_q[g] <= wdata;
  end

  always_comb begin
    case (idx)
      I_RX:    rd_mux = DW'(rx_q);
      I_TX:    rd_mux = tx_q;
      I_ST:    rd_mux = DW'(status);
      default: rd_mux = gen_q[idx - 3];
    endcase
  end

  // R2
  rx_rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_strobe) |=> !status[B_RRDY]);
  // R6
  rx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> (status[B_RRDY] && rx_q == $past(rx_byte)));
  // R4
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> (tx_strobe && tx_byte == $past(wdata[BW-1:0])));
  // R4
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(wr_tx));
  // R8
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && status[B_RRDY] && !rd_rx) |=> (status[3] && status[8]));
  // R3
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !rx_strobe && !cts_edge && !wr_tx) |=> ((status & CLR_MASK) == '0));
  // R5
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == I_RX && !rx_strobe) |=> $stable(rx_q));
endmodule

// File: tb/uart_regfile_test.sv
module uart_regfile_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 0, rd_en = 0, tx_busy = 0, rx_strobe = 0, cts_edge = 0;
  logic [31:0] wdata = '0;
  logic [7:0]  rx_byte = '0;
  logic [2:0]  rx_err = '0;
  logic [31:0] rdata;
  logic        tx_strobe, irq;
  logic [7:0]  tx_byte;
  int errors = 0, checks = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  uart_regfile uut (.clk, .rst_n, .addr, .wr_en, .wdata, .rd_en, .rdata,
    .tx_strobe, .tx_byte, .tx_busy, .rx_strobe, .rx_byte, .rx_err, .cts_edge, .irq);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic rx(logic [7:0] b, logic [2:0] e);
    @(negedge clk); rx_byte = b; rx_err = e; rx_strobe = 1;
    @(negedge clk); rx_strobe = 0; rx_err = 0;
  endtask

  // {is_write, byte address, data or expected}
  localparam logic [48:0] VEC [10] = '{
    {1'b1, 16'h0010, 32'hDEAD_BEEF}, {1'b1, 16'h0014, 32'h0000_0001},
    {1'b1, 16'h0018, 32'hA5A5_5A5A}, {1'b1, 16'h003C, 32'h8000_0000},
    {1'b0, 16'h0010, 32'hDEAD_BEEF}, {1'b0, 16'h0034, 32'h0000_0001},
    {1'b0, 16'h0018, 32'hA5A5_5A5A}, {1'b0, 16'h001C, 32'h8000_0000},
    {1'b1, 16'h002C, 32'h0000_0000}, {1'b0, 16'h000C, 32'h0000_0000}};

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 rdata reset", rdata, 0);
    chk("R12 irq reset", 32'(irq), 0);
    rst_n = 1;
    rd(16'h08, v); chk("R12 status reset", v, 32'h20);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][48]) wr(VEC[i][47:32], VEC[i][31:0]);
      else begin rd(VEC[i][47:32], v); chk("R7/R1 table", v, VEC[i][31:0]); end
    end

    rx(8'h5A, 3'b000);
    rd(16'h08, v); chk("R6 status after rx", v, 32'hA0);
    rd(16'h00, v); chk("R2 rx data", v, 32'h5A);
    rd(16'h08, v); chk("R2 ready cleared", v, 32'h20);
    rd(16'h00, v); chk("R2 byte kept", v, 32'h5A);

    rx(8'h11, 3'b000); rx(8'h22, 3'b000);
    rd(16'h08, v); chk("R8 overrun status", v, 32'h1A8);
    rd(16'h08, v); chk("R3 cleared, ready kept", v, 32'hA0);
    wr(16'h00, 32'hFF); wr(16'h08, 32'h1FF);
    rd(16'h00, v); chk("R5/R8 rx write ignored", v, 32'h22);
    rd(16'h08, v); chk("R5 status write ignored", v, 32'h20);

    rx(8'h33, 3'b101);
    rd(16'h08, v); chk("R6 parity+break", v, 32'h1A5);
    rd(16'h00, v);

    @(negedge clk); addr = 16'h04; wdata = 32'h1234_56C3; wr_en = 1;
    @(negedge clk); wr_en = 0;
    chk("R4 strobe", 32'(tx_strobe), 1); chk("R4 byte", 32'(tx_byte), 32'hC3);
    @(negedge clk); chk("R4 single pulse", 32'(tx_strobe), 0);
    rd(16'h04, v); chk("R4 readback", v, 32'h1234_56C3);

    tx_busy = 1; wr(16'h04, 32'h41);
    rd(16'h08, v); chk("R9 tx overrun", v, 32'h110);
    rd(16'h08, v); chk("R9 cleared", v, 32'h0);
    tx_busy = 0;

    wr(16'h0C, 32'h80); chk("R10 no irq", 32'(irq), 0);
    rx(8'h44, 3'b000); chk("R10 irq rx ready", 32'(irq), 1);
    rd(16'h00, v); chk("R10 irq after rx read", 32'(irq), 0);
    wr(16'h0C, 32'h20); chk("R10 irq tx ready", 32'(irq), 1);
    wr(16'h0C, 32'h40); chk("R10 masked", 32'(irq), 0);
    @(negedge clk); cts_edge = 1; @(negedge clk); cts_edge = 0;
    chk("R10 irq cts", 32'(irq), 1);
    rd(16'h08, v); chk("R3 cts bit", v, 32'h60);
    chk("R10 irq cleared by status read", 32'(irq), 0);
    wr(16'h0C, 32'h0);

    rx(8'h55, 3'b000);
    @(negedge clk); addr = 16'h00; rd_en = 1; rx_byte = 8'h66; rx_strobe = 1;
    @(negedge clk); rd_en = 0; rx_strobe = 0;
    chk("R11 old byte returned", rdata, 32'h55);
    rd(16'h08, v); chk("R11 ready stays, no overrun", v, 32'hA0);
    rd(16'h00, v); chk("R11 new byte", v, 32'h66);
    @(negedge clk); addr = 16'h08; rd_en = 1; rx_byte = 8'h77; rx_err = 3'b010; rx_strobe = 1;
    @(negedge clk); rd_en = 0; rx_strobe = 0; rx_err = 0;
    chk("R11 status pre-event", rdata, 32'h20);
    rd(16'h08, v); chk("R11 set beats clear", v, 32'h1A2);

    wr(16'h10, 32'hCAFE); wr(16'h0C, 32'h80); rx(8'h01, 3'b000);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R12 irq in reset", 32'(irq), 0);
    chk("R12 rdata in reset", rdata, 0);
    rst_n = 1;
    rd(16'h10, v); chk("R12 general cleared", v, 0);
    rd(16'h00, v); chk("R12 rx cleared", v, 0);
    rd(16'h08, v); chk("R12 status cleared", v, 32'h20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule